// File: doc/BRIEF.md
# Iterative Integer Divider

This block divides a dividend by a divisor of the same width (64 bits by default) and returns the quotient. It is built for a core that issues one division at a time. The divisor may be zero, and in signed mode the dividend may be the most negative value with a divisor of minus one. A mode input chooses between unsigned and two's-complement operation. The caller raises `start` for one cycle with the operands. The block is then `busy` while it works, and it raises `done` for one cycle when the quotient is ready.

Normal divisions run a restoring shift-subtract loop on the operand magnitudes. The loop produces one quotient bit per clock. The quotient is negated at the end when a signed division has operands of opposite sign, so signed results truncate toward zero. Two cases skip the loop and give fixed results without any trap or flag:

- A divisor of zero gives a quotient of zero in either mode.
- In signed mode, the most negative value divided by minus one returns the most negative value.

Top module: `iterDivider`

## Requirements
- R1: A synchronous active-high reset drives `busy` and `done` low in the cycle after the reset edge, including when a division is in progress.
- R2: In unsigned mode (`signedMode` = 0) with a non-zero divisor, the quotient is the floor of dividend / divisor, both operands read as unsigned.
- R3: In signed mode (`signedMode` = 1), when the divisor is non-zero and the pair is not the most-negative / minus-one pair, the quotient is the two's-complement quotient truncated toward zero.
- R4: A divisor of zero gives a quotient of zero in both modes.
- R5: In signed mode, a dividend with only the top bit set divided by the all-ones divisor returns the dividend unchanged.
- R6: In unsigned mode, that same bit pattern divided by all-ones is an ordinary division that gives 0 and takes the full-length path.
- R7: For a normal division accepted at a clock edge, `busy` is high for exactly WIDTH cycles after that edge, and `done` is high in the cycle after those.
- R8: For either case of R4 and R5, `done` is high in the cycle right after the accepting edge, and `busy` never rises.
- R9: `done` is high for one cycle only, unless a new start is accepted in that cycle. `quotient` holds its value until the next start is accepted.
- R10: A `start` while `busy` is high is ignored: the running division's result and completion cycle are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division; sampled when not busy |
| signedMode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | WIDTH | Dividend, latched when start is accepted |
| divisor | input | WIDTH | Divisor, latched when start is accepted |
| busy | output | 1 | Iterative loop running |
| done | output | 1 | One-cycle pulse: quotient is ready |
| quotient | output | WIDTH | Result; valid from done until the next accepted start |

## Verification
The bench builds the main instance with WIDTH = 6. At that width all 4096 operand pairs in both modes can be swept in a few tens of thousands of cycles. The sweep covers every sign combination, every zero divisor, the most-negative/minus-one pair and the matching unsigned bit pattern, and it checks the latency of each division. A second instance at the default WIDTH of 64 runs a few directed cases. These confirm that the full-width loop and both fixed results behave the same way when the operands are large.

// File: rtl/iterDivPkg.sv
`timescale 1ns/1ps
package iterDivPkg;
  // Strobes from the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic loadOps;      // capture magnitudes and clear the partial remainder
    logic loadSpecial;  // write the fixed result straight to the quotient
    logic stepEn;       // produce one quotient bit
    logic finish;       // final step: write the signed-corrected quotient
  } divStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } divState_t;
endpackage

// File: rtl/divOperandPrep.sv
`timescale 1ns/1ps
module divOperandPrep #(
  parameter int WIDTH = 64
) (
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] dividendMag,
  output logic [WIDTH-1:0] divisorMag,
  output logic             negResult,
  output logic             specialHit,
  output logic [WIDTH-1:0] specialValue
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic dividendNeg, divisorNeg, zeroDiv, signedOvf;

  always_comb begin
    dividendNeg = signedMode & dividend[WIDTH-1];
    divisorNeg  = signedMode & divisor[WIDTH-1];
    // Negating the most negative value yields the same pattern, which read
    // unsigned is its true magnitude.
    dividendMag = dividendNeg ? (~dividend + 1'b1) : dividend;
    divisorMag  = divisorNeg  ? (~divisor  + 1'b1) : divisor;
    negResult   = dividendNeg ^ divisorNeg;

    zeroDiv    = (divisor == '0);
    signedOvf  = signedMode && (dividend == MOST_NEG) && (divisor == ALL_ONES);
    specialHit = zeroDiv | signedOvf;
    specialValue = zeroDiv ? '0 : MOST_NEG;
  end
endmodule

// File: rtl/divControl.sv
`timescale 1ns/1ps
module divControl
  import iterDivPkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        specialHit,
  output divStrobes_t strobes,
  output logic        busy,
  output logic        done
);
  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  divState_t        state, nextState;
  logic [CNT_W-1:0] count, nextCount;

  always_comb begin
    strobes   = '0;
    nextState = state;
    nextCount = count;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        nextState = ST_IDLE;
        if (start) begin
          if (specialHit) begin
            strobes.loadSpecial = 1'b1;
            nextState           = ST_DONE;
          end else begin
            strobes.loadOps = 1'b1;
            nextState       = ST_RUN;
            nextCount       = '0;
          end
        end
      end
      ST_RUN: begin
        strobes.stepEn = 1'b1;
        nextCount      = count + CNT_W'(1);
        if (count == LAST) begin
          strobes.finish = 1'b1;
          nextState      = ST_DONE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      count <= '0;
    end else begin
      state <= nextState;
      count <= nextCount;
    end
  end

  assign busy = (state == ST_RUN);
  assign done = (state == ST_DONE);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!busy && !done));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done);

  // R7 and R10: the loop advances by one each cycle whatever start does
  run_count_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && count != LAST) |=> (busy && count == $past(count) + CNT_W'(1)));

  // R8
  done_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(busy) || $past(start)));
endmodule

// File: rtl/divDatapath.sv
`timescale 1ns/1ps
module divDatapath
  import iterDivPkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  divStrobes_t      strobes,
  input  logic [WIDTH-1:0] dividendMag,
  input  logic [WIDTH-1:0] divisorMag,
  input  logic             negResult,
  input  logic [WIDTH-1:0] specialValue,
  output logic [WIDTH-1:0] quotient
);
  logic [WIDTH-1:0] remReg, quoReg, divReg;
  logic             negReg;
  logic [WIDTH:0]   shifted, trial;
  logic             fits;
  logic [WIDTH-1:0] nextRem, nextQuo;

  always_comb begin
    shifted = {remReg, quoReg[WIDTH-1]};
    trial   = shifted - {1'b0, divReg};
    fits    = ~trial[WIDTH];
    nextRem = fits ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
    nextQuo = {quoReg[WIDTH-2:0], fits};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remReg   <= '0;
      quoReg   <= '0;
      divReg   <= '0;
      negReg   <= 1'b0;
      quotient <= '0;
    end else begin
      if (strobes.loadOps) begin
        remReg <= '0;
        quoReg <= dividendMag;
        divReg <= divisorMag;
        negReg <= negResult;
      end else if (strobes.stepEn) begin
        remReg <= nextRem;
        quoReg <= nextQuo;
      end
      if (strobes.loadSpecial)
        quotient <= specialValue;
      else if (strobes.finish)
        quotient <= negReg ? (~nextQuo + 1'b1) : nextQuo;
    end
  end

  // R2: the partial remainder stays below the divisor magnitude on every step
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.stepEn |-> (remReg < divReg));
endmodule

// File: rtl/iterDivider.sv
`timescale 1ns/1ps
module iterDivider
  import iterDivPkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  divStrobes_t      strobes;
  logic [WIDTH-1:0] dividendMag, divisorMag, specialValue;
  logic             negResult, specialHit;

  divOperandPrep #(.WIDTH(WIDTH)) prep (
    .signedMode  (signedMode),
    .dividend    (dividend),
    .divisor     (divisor),
    .dividendMag (dividendMag),
    .divisorMag  (divisorMag),
    .negResult   (negResult),
    .specialHit  (specialHit),
    .specialValue(specialValue)
  );

  divControl #(.WIDTH(WIDTH)) ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .specialHit(specialHit),
    .strobes   (strobes),
    .busy      (busy),
    .done      (done)
  );

  divDatapath #(.WIDTH(WIDTH)) dpath (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .dividendMag (dividendMag),
    .divisorMag  (divisorMag),
    .negResult   (negResult),
    .specialValue(specialValue),
    .quotient    (quotient)
  );

  // R4
  zero_div_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor == '0) |=> (done && quotient == '0));

  // R5
  min_neg_one_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && signedMode && dividend == MOST_NEG && divisor == '1)
      |=> (done && quotient == MOST_NEG));
endmodule

// File: tb/iterDivider_test.sv
`timescale 1ns/1ps
module iterDivider_test;
  localparam int SW = 6;
  localparam int WW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          start = 0, sMode = 0;
  logic [SW-1:0] opA = '0, opB = '0;
  logic          busy, done;
  logic [SW-1:0] quotient;

  logic          wStart = 0, wMode = 0;
  logic [WW-1:0] wA = '0, wB = '0;
  logic          wBusy, wDone;
  logic [WW-1:0] wQuot;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 0;

  iterDivider #(.WIDTH(SW)) uut (
    .clk(clk), .rst(rst), .start(start), .signedMode(sMode),
    .dividend(opA), .divisor(opB), .busy(busy), .done(done), .quotient(quotient));

  iterDivider #(.WIDTH(WW)) uutWide (
    .clk(clk), .rst(rst), .start(wStart), .signedMode(wMode),
    .dividend(wA), .divisor(wB), .busy(wBusy), .done(wDone), .quotient(wQuot));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [SW-1:0] refQuot(input bit s, input logic [SW-1:0] a, input logic [SW-1:0] b);
    int sa, sb;
    if (b == '0) return '0;
    if (!s) return a / b;
    sa = $signed(a);
    sb = $signed(b);
    if (sa == -(2 ** (SW - 1)) && sb == -1) return a;
    return SW'(sa / sb);
  endfunction

  task automatic runSmall(input bit s, input logic [SW-1:0] a, input logic [SW-1:0] b);
    logic [SW-1:0] expQ;
    bit special;
    int cyc, busyCyc;
    string tag;
    expQ = refQuot(s, a, b);
    special = (b == '0) || (s && a == {1'b1, {(SW-1){1'b0}}} && b == '1);
    if (b == '0) tag = "R4";
    else if (special) tag = "R5";
    else if (!s && a == {1'b1, {(SW-1){1'b0}}} && b == '1) tag = "R6";
    else if (s) tag = "R3";
    else tag = "R2";
    @(negedge clk);
    sMode = s; opA = a; opB = b; start = 1;
    @(negedge clk);
    start = 0; cyc = 1; busyCyc = 0;
    while (!done && cyc < 200) begin
      if (busy) busyCyc++;
      @(negedge clk);
      cyc++;
    end
    check(quotient == expQ, tag, 64'(quotient), 64'(expQ));
    if (special)
      check(cyc == 1 && busyCyc == 0, "R8 latency", 64'(cyc), 64'(1));
    else
      check(cyc == SW + 1 && busyCyc == SW, "R7 latency", 64'(cyc), 64'(SW + 1));
  endtask

  task automatic runWide(input bit s, input logic [WW-1:0] a, input logic [WW-1:0] b,
                         input logic [WW-1:0] expQ, input string tag, input int expCyc);
    int cyc;
    @(negedge clk);
    wMode = s; wA = a; wB = b; wStart = 1;
    @(negedge clk);
    wStart = 0; cyc = 1;
    while (!wDone && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    check(wQuot == expQ, tag, wQuot, expQ);
    check(cyc == expCyc, {tag, " wide latency R7/R8"}, 64'(cyc), 64'(expCyc));
  endtask

  initial begin
    logic [WW-1:0] minW;
    int cyc;
    minW = {1'b1, {(WW-1){1'b0}}};
    repeat (3) @(negedge clk);
    // R1: outputs idle while held in reset
    check(!busy && !done, "R1 reset state", {62'b0, busy, done}, 64'd0);
    rst = 0;

    // R1: reset in the middle of a running division
    @(negedge clk);
    sMode = 0; opA = 6'd50; opB = 6'd3; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    check(!busy && !done, "R1 reset mid-run", {62'b0, busy, done}, 64'd0);
    rst = 0;
    repeat (SW + 2) @(negedge clk);
    check(!done && !busy, "R1 stays idle after reset", {62'b0, busy, done}, 64'd0);

    // R2..R8: exhaustive sweep of the small instance
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 2 ** SW; a++)
        for (int b = 0; b < 2 ** SW; b++)
          runSmall(s[0], SW'(a), SW'(b));

    // R9: done drops after one cycle, quotient holds
    runSmall(1'b1, 6'd45, 6'd7);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!done && quotient == refQuot(1'b1, 6'd45, 6'd7), "R9 hold",
            {57'b0, done, quotient}, 64'(refQuot(1'b1, 6'd45, 6'd7)));
    end

    // R10: start during busy is ignored
    @(negedge clk);
    sMode = 0; opA = 6'd61; opB = 6'd4; start = 1;
    @(negedge clk);
    opA = 6'd7; opB = 6'd0; sMode = 1; cyc = 1;
    @(negedge clk); cyc++;
    @(negedge clk); cyc++;
    start = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    check(quotient == 6'd15, "R10 result", 64'(quotient), 64'd15);
    check(cyc == SW + 1, "R10 timing", 64'(cyc), 64'(SW + 1));

    // Wide instance, default width
    runWide(1'b0, '1, 64'd3, 64'hFFFF_FFFF_FFFF_FFFF / 64'd3, "R2", WW + 1);
    runWide(1'b1, 64'(-longint'(100)), 64'd7, 64'(-longint'(100) / longint'(7)), "R3", WW + 1);
    runWide(1'b1, 64'd7, 64'(-longint'(2)), 64'(longint'(7) / -longint'(2)), "R3", WW + 1);
    runWide(1'b1, minW, 64'd1, minW, "R3", WW + 1);
    runWide(1'b0, 64'd12345, '0, '0, "R4", 1);
    runWide(1'b1, 64'(-longint'(9)), '0, '0, "R4", 1);
    runWide(1'b1, minW, '1, minW, "R5", 1);
    runWide(1'b0, minW, '1, '0, "R6", WW + 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule